// File: doc/BRIEF.md
# Latching Two-Phase PWM Controller

This block is the digital core of a regulating pulse-width modulator for a push-pull switching converter. A free-running period counter produces a ramp. The first few counts of every period form a blanking window that sets the dead time. Outside that window a pulse is active while the ramp is below the effective duty. The effective duty is the smaller of the external duty command and an internal soft-start value. A termination latch stops any pulse from starting again within a period once it has ended. A phase flip-flop toggles at every period start and sends alternate periods to output A and output B.

Protection has three parts. A shutdown input kills the active pulse at once through the termination latch. If shutdown is held long enough, it also discharges the soft-start value. An undervoltage lockout watches a digital supply-level word, with separate assert and release thresholds. While locked, the lockout forces both outputs off and pins soft-start at zero. A rising edge on the sync input restarts the period early, so several controllers can share one system clock. A parameter selects whether an output that is off is driven low or high.

Top module: `pp_pwm_ctrl`

## Requirements
- R1: The period counter runs from 0 to PERIOD-1 and wraps. Each wrap toggles the phase, and the first period after reset belongs to output A. Output A may be active only in even periods and output B only in odd periods, so the two outputs are never active together.
- R2: While the counter is below DEAD_CYCLES, both outputs are off.
- R3: An output is active while the counter is at least DEAD_CYCLES, below the effective duty, and no termination, shutdown or lockout applies. A duty command of 0 never activates an output.
- R4: Once the pulse of a period has ended, no output becomes active again before the next period starts, even if the duty command is raised.
- R5: Shutdown high turns the active output off in the same cycle. A shutdown of one cycle keeps both outputs off for the rest of that period, and the following period runs normally.
- R6: Shutdown held for more than SD_HOLD consecutive cycles sets the soft-start value to zero, so the pulse width ramps up again after release.
- R7: While lockout is active, both outputs are off and the soft-start value is held at zero. Lockout is active from reset.
- R8: Lockout releases one cycle after the supply word is at least UV_ON. It asserts one cycle after the supply word falls below UV_OFF, where UV_OFF < UV_ON. Between the two thresholds, the lockout state does not change.
- R9: The soft-start value rises by one every SS_DIV clocks and saturates at PERIOD. The effective duty is the minimum of the duty command and the soft-start value.
- R10: A rising edge on sync_in starts a new period. The counter is 0 in the next cycle, the phase toggles, and the termination latch clears. A sync input that is held high has no further effect.
- R11: With OFF_HIGH = 0, an off output is driven 0 and an active output is driven 1. With OFF_HIGH = 1, both levels are inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_in | input | 1 | External sync; a rising edge restarts the period |
| shutdown | input | 1 | Shutdown request, active high |
| supply_lvl | input | SUP_W | Digital supply-level word for the lockout |
| duty_cmd | input | $clog2(PERIOD+1) | Duty command in counter steps, 0..PERIOD |
| out_a | output | 1 | Phase A drive |
| out_b | output | 1 | Phase B drive |

## Verification
The bench builds the block with PERIOD = 16, DEAD_CYCLES = 2, SS_DIV = 2, SD_HOLD = 5 and lockout thresholds of 100 and 80 on an 8-bit supply word. With these values the soft-start ramp reaches full scale within 32 clocks, and a held shutdown discharges after only six cycles, so ramp, discharge and re-ramp all fit in a few periods. Two instances with opposite OFF_HIGH settings share the same inputs, so every cycle checks the inverted polarity against the same model. Supply values of 40, 90 and 120 fall below, between and above the thresholds, which exercises the hysteresis band in both directions.

// File: rtl/pp_pwm_pkg.sv
package pp_pwm_pkg;

  // smaller of two values
  function automatic int min_i(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // increment that stops at a limit
  function automatic int sat_inc(input int v, input int lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // lockout next state: leaves lock at or above on_lvl, enters it below off_lvl
  function automatic logic uv_next(input logic locked, input int lvl,
                                   input int on_lvl, input int off_lvl);
    if (locked) return !(lvl >= on_lvl);
    return lvl < off_lvl;
  endfunction

endpackage

// File: rtl/pp_period_gen.sv
module pp_period_gen #(
  parameter int PERIOD = 64,
  parameter int CNT_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  output logic [CNT_W-1:0] cnt,
  output logic             tick
);
  logic             sync_q;
  logic             sync_rise;
  logic             wrap;
  logic [CNT_W-1:0] cnt_q;

  assign sync_rise = sync_in & ~sync_q;
  assign wrap      = (cnt_q == CNT_W'(PERIOD - 1));
  assign tick      = wrap | sync_rise;
  assign cnt       = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_q <= sync_in;
      cnt_q  <= tick ? '0 : cnt_q + 1'b1;
    end
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0)); // R1
  AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    sync_rise |=> (cnt_q == '0)); // R10
  AST_LEVEL_SYNC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q && sync_in && !wrap) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R10
endmodule

// File: rtl/pp_softstart.sv
module pp_softstart #(
  parameter int PERIOD  = 64,
  parameter int SS_DIV  = 4,
  parameter int SD_HOLD = 32,
  parameter int DUTY_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shutdown,
  input  logic              uvlo,
  output logic [DUTY_W-1:0] ss_val
);
  localparam int DIV_W = $clog2(SS_DIV + 1);
  localparam int SDC_W = $clog2(SD_HOLD + 1);

  logic [DUTY_W-1:0] ss_q;
  logic [DIV_W-1:0]  div_q;
  logic [SDC_W-1:0]  sdc_q;
  logic              sd_long;
  logic              ss_clear;
  logic              ss_step;

  assign sd_long  = shutdown && (sdc_q == SDC_W'(SD_HOLD));
  assign ss_clear = uvlo | sd_long;
  assign ss_step  = (div_q == DIV_W'(SS_DIV - 1));
  assign ss_val   = ss_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ss_q  <= '0;
      div_q <= '0;
      sdc_q <= '0;
    end else begin
      sdc_q <= shutdown ? SDC_W'(pp_pwm_pkg::sat_inc(int'(sdc_q), SD_HOLD)) : '0;
      if (ss_clear) begin
        ss_q  <= '0;
        div_q <= '0;
      end else if (ss_step) begin
        div_q <= '0;
        ss_q  <= DUTY_W'(pp_pwm_pkg::sat_inc(int'(ss_q), PERIOD));
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  AST_SS_DISCHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    sd_long |=> (ss_q == '0)); // R6
  AST_SS_LOCK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> (ss_q == '0)); // R7
  AST_SS_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_clear |=> ({1'b0, ss_q} <= {1'b0, $past(ss_q)} + 1'b1)); // R9
  AST_SS_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ss_q) <= PERIOD); // R9
endmodule

// File: rtl/pp_uvlo.sv
module pp_uvlo #(
  parameter int SUP_W  = 8,
  parameter int UV_ON  = 200,
  parameter int UV_OFF = 180
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SUP_W-1:0] supply_lvl,
  output logic             uvlo
);
  logic uvlo_q;

  assign uvlo = uvlo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) uvlo_q <= 1'b1;
    else        uvlo_q <= pp_pwm_pkg::uv_next(uvlo_q, int'(supply_lvl), UV_ON, UV_OFF);
  end

  AST_UV_HOLD_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!uvlo_q && int'(supply_lvl) >= UV_OFF) |=> !uvlo_q); // R8
  AST_UV_HOLD_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (uvlo_q && int'(supply_lvl) < UV_ON) |=> uvlo_q); // R8
endmodule

// File: rtl/pp_pwm_ctrl.sv
module pp_pwm_ctrl #(
  parameter int PERIOD      = 64,
  parameter int DEAD_CYCLES = 4,
  parameter int SS_DIV      = 4,
  parameter int SD_HOLD     = 32,
  parameter int SUP_W       = 8,
  parameter int UV_ON       = 200,
  parameter int UV_OFF      = 180,
  parameter bit OFF_HIGH    = 1'b0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sync_in,
  input  logic                         shutdown,
  input  logic [SUP_W-1:0]             supply_lvl,
  input  logic [$clog2(PERIOD+1)-1:0]  duty_cmd,
  output logic                         out_a,
  output logic                         out_b
);
  localparam int CNT_W  = $clog2(PERIOD);
  localparam int DUTY_W = $clog2(PERIOD + 1);
  localparam logic [CNT_W-1:0] DEAD_C = CNT_W'(DEAD_CYCLES);

  logic [CNT_W-1:0]  cnt;
  logic              tick;
  logic [DUTY_W-1:0] ss_val;
  logic              uvlo;
  logic [DUTY_W-1:0] duty_eff;
  logic              in_blank;
  logic              under_duty;
  logic              pulse_end;
  logic              term_set;
  logic              pulse_on;
  logic              act_a;
  logic              act_b;
  logic              term_q;
  logic              phase_q;

  pp_period_gen #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_period (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .cnt(cnt), .tick(tick));

  pp_softstart #(.PERIOD(PERIOD), .SS_DIV(SS_DIV), .SD_HOLD(SD_HOLD), .DUTY_W(DUTY_W)) u_ss (
    .clk(clk), .rst_n(rst_n), .shutdown(shutdown), .uvlo(uvlo), .ss_val(ss_val));

  pp_uvlo #(.SUP_W(SUP_W), .UV_ON(UV_ON), .UV_OFF(UV_OFF)) u_uvlo (
    .clk(clk), .rst_n(rst_n), .supply_lvl(supply_lvl), .uvlo(uvlo));

  assign duty_eff   = DUTY_W'(pp_pwm_pkg::min_i(int'(duty_cmd), int'(ss_val)));
  assign in_blank   = (cnt < DEAD_C);
  assign under_duty = (DUTY_W'(cnt) < duty_eff);
  assign pulse_end  = !in_blank && !under_duty;
  assign term_set   = shutdown | uvlo | pulse_end;
  assign pulse_on   = !in_blank && under_duty && !term_q && !shutdown && !uvlo;
  assign act_a      = pulse_on & ~phase_q;
  assign act_b      = pulse_on &  phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      term_q  <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      term_q <= tick ? 1'b0 : (term_q | term_set);
      if (tick) phase_q <= ~phase_q;
    end
  end

  generate
    if (OFF_HIGH) begin : g_off_high
      assign out_a = ~act_a;
      assign out_b = ~act_b;
    end else begin : g_off_low
      assign out_a = act_a;
      assign out_b = act_b;
    end
  endgenerate

  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_a, act_b})); // R1
  AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (phase_q != $past(phase_q))); // R1
  AST_BLANK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    in_blank |-> !(act_a || act_b)); // R2
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (term_q && !tick) |=> term_q); // R4
  AST_LATCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !term_q); // R10
  AST_SD_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> !(act_a || act_b)); // R5
  AST_LOCK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |-> !(act_a || act_b)); // R7
endmodule

// File: tb/sim_pp_pwm_ctrl.sv
module sim_pp_pwm_ctrl;
  localparam int P = 16, D = 2, DIV = 2, H = 5, SW = 8, ON = 100, OFF = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_in = 1'b0;
  logic shutdown = 1'b0;
  logic [SW-1:0] supply = 8'd40;
  logic [4:0] duty = 5'd0;
  logic a0, b0, a1, b1;

  int total = 0, bad = 0;
  string tag = "R11";
  bit done = 0;

  // behavioural reference state
  int m_cnt = 0, m_term = 0, m_ph = 0, m_ss = 0, m_div = 0, m_sdc = 0, m_uv = 1;
  bit m_sync_prev = 0;

  int wa, wb;

  always #5 clk = ~clk;

  pp_pwm_ctrl #(.PERIOD(P), .DEAD_CYCLES(D), .SS_DIV(DIV), .SD_HOLD(H), .SUP_W(SW),
                .UV_ON(ON), .UV_OFF(OFF), .OFF_HIGH(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .shutdown(shutdown),
    .supply_lvl(supply), .duty_cmd(duty), .out_a(a0), .out_b(b0));

  pp_pwm_ctrl #(.PERIOD(P), .DEAD_CYCLES(D), .SS_DIV(DIV), .SD_HOLD(H), .SUP_W(SW),
                .UV_ON(ON), .UV_OFF(OFF), .OFF_HIGH(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .shutdown(shutdown),
    .supply_lvl(supply), .duty_cmd(duty), .out_a(a1), .out_b(b1));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // model advance on each clock edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_term = 0; m_ph = 0; m_ss = 0; m_div = 0; m_sdc = 0; m_uv = 1;
      m_sync_prev = 0;
    end else begin
      bit rise, new_per, long_sd;
      int lim, stop;
      rise    = sync_in && !m_sync_prev;
      new_per = (m_cnt == P - 1) || rise;
      lim     = (int'(duty) < m_ss) ? int'(duty) : m_ss;
      stop    = (m_cnt >= D && m_cnt >= lim) || shutdown || (m_uv != 0);
      long_sd = shutdown && (m_sdc == H);
      if (new_per) begin m_term = 0; m_ph = 1 - m_ph; m_cnt = 0; end
      else begin if (stop) m_term = 1; m_cnt++; end
      if (m_uv != 0 || long_sd) begin m_ss = 0; m_div = 0; end
      else if (m_div == DIV - 1) begin m_div = 0; if (m_ss < P) m_ss++; end
      else m_div++;
      m_sdc = shutdown ? ((m_sdc < H) ? m_sdc + 1 : H) : 0;
      if (m_uv != 0) m_uv = (int'(supply) >= ON) ? 0 : 1;
      else           m_uv = (int'(supply) < OFF) ? 1 : 0;
      m_sync_prev = sync_in;
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int lim, on, ea, eb;
      lim = (int'(duty) < m_ss) ? int'(duty) : m_ss;
      on  = (m_cnt >= D && m_cnt < lim && m_term == 0 && !shutdown && m_uv == 0) ? 1 : 0;
      ea  = (on != 0 && m_ph == 0) ? 1 : 0;
      eb  = (on != 0 && m_ph == 1) ? 1 : 0;
      check(tag, {30'd0, a0, b0}, ea * 2 + eb);
      check({tag, "/R11"}, {30'd0, a1, b1}, (1 - ea) * 2 + (1 - eb));
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic align(input int k);
    do begin @(posedge clk); #1; end while (m_cnt != k);
  endtask

  task automatic win(input int n);
    wa = 0; wb = 0;
    repeat (n) begin @(negedge clk); wa += int'(a0); wb += int'(b0); end
    @(posedge clk); #1;
  endtask

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    #3;
    check("R11 reset u0", {30'd0, a0, b0}, 0);
    check("R11 reset u1", {30'd0, a1, b1}, 3);
    // R7 / R8: locked from reset, supply below and between thresholds
    tag = "R7"; duty = 5'd10;
    win(20);
    check("R7 locked active", wa + wb, 0);
    tag = "R8"; supply = 8'd90;
    win(20);
    check("R8 between thresholds stays locked", wa + wb, 0);
    supply = 8'd120;
    tag = "R9";
    step(40);
    // R1 / R2 / R3 / R9 steady state: duty 10 -> counts 2..9 active
    tag = "R1";
    align(P - 1); step(1);
    win(2 * P);
    check("R1 phase A count", wa, 8);
    check("R1 phase B count", wb, 8);
    tag = "R2"; duty = 5'd16;
    align(P - 1); step(1);
    win(P);
    check("R2 blanking trims full duty", wa + wb, P - D);
    tag = "R3"; duty = 5'd0;
    win(2 * P);
    check("R3 zero duty", wa + wb, 0);
    // R4: raise duty after the pulse ended
    tag = "R4"; duty = 5'd5;
    align(6);
    duty = 5'd14;
    win(9);
    check("R4 no retrigger", wa + wb, 0);
    // R5: one-cycle shutdown mid pulse
    tag = "R5";
    align(4);
    shutdown = 1'b1;
    step(1);
    shutdown = 1'b0;
    win(10);
    check("R5 rest of period off", wa + wb, 0);
    align(P - 1); step(1);
    win(P);
    check("R5 next period normal", wa + wb, 12);
    // R6: long shutdown discharges soft-start
    tag = "R6";
    shutdown = 1'b1;
    step(H + 4);
    shutdown = 1'b0;
    align(P - 1); step(1);
    win(P);
    total++;
    if (wa + wb >= 12) begin
      bad++;
      $display("FAIL R6: actual=%0d expected=<12", wa + wb);
    end
    step(3 * P);
    // R10: sync rising edge restarts the period; held level ignored
    tag = "R10";
    align(8);
    sync_in = 1'b1;
    step(1);
    win(14);
    check("R10 restarted period width", wa + wb, 12);
    sync_in = 1'b0;
    step(P);
    // R7 / R8: drop below assert threshold, then hysteresis band
    tag = "R7"; supply = 8'd70;
    step(1);
    win(20);
    check("R7 lockout forces off", wa + wb, 0);
    tag = "R8"; supply = 8'd90;
    win(20);
    check("R8 band keeps lock", wa + wb, 0);
    supply = 8'd120;
    tag = "R9";
    step(3 * P);
    supply = 8'd90;
    tag = "R8";
    win(2 * P);
    check("R8 band keeps run", wa + wb, 24);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule